// File: doc/BRIEF.md
# Four-Channel DMA Request Arbiter

This block sits in front of a DMA transfer engine. It collects transfer requests for four channels and hands the engine one channel at a time. It drives a per-channel acknowledge strobe and controls a shared terminal-count line. Each channel takes its request from one of three kinds of source: a software request bit, an active-low external request pin, or one of the internal peripheral request lines. A 4-bit source code in the channel's control register picks the source. External pins can be sensed on an edge or on a level.

A byte-wide register bus gives access to two global registers and four channel registers. A per-channel counter-zero strobe from the engine makes the block pulse the open-drain terminal-count line low for a single cycle. A falling edge that some other agent causes on that same line cancels the transfer that is running. The engine sees the grant as a valid flag plus a channel number. It ends a transfer with a done strobe, or the block ends it with a cancel strobe.

Top module: `dmarb_top`

## Requirements
- R1: After a synchronous reset, no grant is active and acknowledge and terminal-count drive are low. Every register reads 0.
- R2: Register map by address. At 0 the global control register reads {req_flags[3:0], 2'b00, tc_en, prio_rr}, and writes to its upper nibble are ignored. At 1 the enable register reads {ch_en[3:0], sw_req[3:0]}. At 4+i the control register of channel i reads {2'b00, ack_en, edge_mode, src[3:0]}.
- R3: A channel with ch_en=0 never latches a request and is never granted.
- R4: With prio_rr=0, among pending channels the lowest channel number wins.
- R5: With prio_rr=1, the search starts at the channel after the one granted most recently, wrapping 3 to 0. After reset the most recent channel counts as 3.
- R6: A software bit requests in any source mode. src=4'b0001 selects the channel's external pin. src values 2 to 15 select periph_req[src], where a one-cycle high pulse latches a request. Other periph lines have no effect.
- R7: With edge_mode=1, a synchronized high-to-low pin transition latches a request, which is cleared on grant. A pin held low does not request again.
- R8: With edge_mode=0, the channel requests for as long as its synchronized pin is low, so it is granted again after each done.
- R9: Only one grant is active at a time. Channel and validity hold until xfer_done or xfer_cancel, after which the arbiter returns to idle.
- R10: ack[i] (channels 0 to 2) is high only while channel i is granted and its ack_en is 1. Channel 3 has no acknowledge.
- R11: With tc_en=1, the rising edge of the active channel's counter-zero strobe drives tc_drive_low for exactly one cycle. With tc_en=0, or for an inactive channel, nothing is driven.
- R12: With tc_en=1, a high-to-low transition on tc_pin_in that the block did not cause itself raises xfer_cancel. The grant ends and the active channel's latched request clears. With tc_en=0 the line is ignored.
- R13: A software request bit clears itself once its channel latches it. It stays set while the channel is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| req_pin_n | input | 4 | Active-low external request pins, one per channel |
| periph_req | input | 16 | Internal peripheral request lines, indexed by source code |
| xfer_done | input | 1 | Engine finished the granted transfer |
| cnt_zero | input | 4 | Per-channel counter or block counter reached zero |
| tc_pin_in | input | 1 | Level sensed on the terminal-count line |
| grant_valid | output | 1 | A channel is granted |
| grant_ch | output | 2 | Granted channel number |
| xfer_cancel | output | 1 | Abort of the granted transfer |
| ack | output | 3 | Acknowledge strobes for channels 0 to 2 |
| tc_drive_low | output | 1 | Open-drain enable that pulls the terminal-count line low |

## Verification
Assertions check the following on every cycle. The grant holds steady until it is ended. At most one acknowledge is high. The terminal-count pulse never lasts more than a cycle and never occurs with the line disabled. A cancel empties the grant and the channel's latched request. A software bit clears once its channel has taken it. Which channel wins under fixed and rotating priority depends on the history of earlier grants, so only the bench's vector sequences show it. The same goes for the difference between edge and level sensing, for the block ignoring its own terminal-count pulse, and for the register readback.

// File: rtl/dmarb_pkg.sv
package dmarb_pkg;

    localparam int NCH    = 4;
    localparam int IDX_W  = $clog2(NCH);
    localparam int SRC_W  = 4;
    localparam int NSRC   = 1 << SRC_W;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] ADDR_GLB  = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] ADDR_ENA  = ADDR_W'(1);
    localparam int                CH_BASE   = 4;

    localparam logic [SRC_W-1:0] SRC_SOFT = SRC_W'(0);
    localparam logic [SRC_W-1:0] SRC_PIN  = SRC_W'(1);

    typedef struct packed {
        logic             ack_en;
        logic             edge_mode;
        logic [SRC_W-1:0] src;
    } ch_ctrl_t;

    typedef struct packed {
        logic tc_en;
        logic prio_rr;
    } glb_ctrl_t;

    typedef enum logic {ARB_IDLE, ARB_BUSY} arb_state_t;

    // Search requests starting at 'start', wrapping; returns {found, index}.
    function automatic logic [IDX_W:0] pick(input logic [NCH-1:0] r,
                                            input logic [IDX_W-1:0] start);
        logic [IDX_W-1:0] idx;
        logic [IDX_W:0]   res;
        res = '0;
        for (int k = NCH - 1; k >= 0; k--) begin
            idx = start + IDX_W'(k);
            if (r[idx]) res = {1'b1, idx};
        end
        return res;
    endfunction

    function automatic logic [NCH-1:0] onehot(input logic [IDX_W-1:0] idx);
        logic [NCH-1:0] v;
        v = '0;
        v[idx] = 1'b1;
        return v;
    endfunction

endpackage

// File: rtl/dmarb_sync.sv
module dmarb_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{RST_VAL}};
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/dmarb_regs.sv
module dmarb_regs
    import dmarb_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   bus_wr,
    input  logic [ADDR_W-1:0]      bus_addr,
    input  logic [DATA_W-1:0]      bus_wdata,
    output logic [DATA_W-1:0]      bus_rdata,
    input  logic [NCH-1:0]         sw_taken,
    input  logic [NCH-1:0]         req_view,
    output glb_ctrl_t              glb,
    output logic [NCH-1:0]         ch_en,
    output logic [NCH-1:0]         sw_req,
    output ch_ctrl_t [NCH-1:0]     ctrl
);
    localparam int CTRL_W = $bits(ch_ctrl_t);

    logic wr_glb, wr_ena;
    assign wr_glb = bus_wr && (bus_addr == ADDR_GLB);
    assign wr_ena = bus_wr && (bus_addr == ADDR_ENA);

    always_ff @(posedge clk) begin
        if (rst) begin
            glb    <= '0;
            ch_en  <= '0;
            sw_req <= '0;
        end else begin
            if (wr_glb) glb <= glb_ctrl_t'(bus_wdata[1:0]);
            if (wr_ena) begin
                ch_en  <= bus_wdata[DATA_W-1 -: NCH];
                sw_req <= bus_wdata[NCH-1:0];
            end else begin
                sw_req <= sw_req & ~sw_taken;
            end
        end
    end

    for (genvar i = 0; i < NCH; i++) begin : g_ctrl
        logic wr_ch;
        assign wr_ch = bus_wr && (bus_addr == ADDR_W'(CH_BASE + i));

        always_ff @(posedge clk) begin
            if (rst)        ctrl[i] <= '0;
            else if (wr_ch) ctrl[i] <= ch_ctrl_t'(bus_wdata[CTRL_W-1:0]);
        end

        // R13: a taken software bit is gone next cycle unless rewritten
        assert_sw_clear_R13: assert property (@(posedge clk) disable iff (rst)
            (sw_req[i] && ch_en[i] && !wr_ena) |=> !sw_req[i]);
    end

    logic [IDX_W-1:0] ch_sel;
    assign ch_sel = IDX_W'(bus_addr - ADDR_W'(CH_BASE));

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_GLB)
            bus_rdata = {req_view, 2'b00, glb.tc_en, glb.prio_rr};
        else if (bus_addr == ADDR_ENA)
            bus_rdata = {ch_en, sw_req};
        else if (int'(bus_addr) >= CH_BASE && int'(bus_addr) < CH_BASE + NCH)
            bus_rdata = DATA_W'(ctrl[ch_sel]);
    end

endmodule

// File: rtl/dmarb_chreq.sv
module dmarb_chreq
    import dmarb_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            pin_n,
    input  ch_ctrl_t        ctrl,
    input  logic            en,
    input  logic            sw_req,
    input  logic [NSRC-1:0] periph_req,
    input  logic            grant_clr,
    input  logic            cancel_clr,
    output logic            req,
    output logic            view,
    output logic            sw_taken
);
    logic pin_s, pin_d, pend;
    logic from_pin, fall, lvl, periph_hit, set;

    dmarb_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_pin_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_n),
        .q   (pin_s)
    );

    always_ff @(posedge clk) begin
        if (rst) pin_d <= 1'b1;
        else     pin_d <= pin_s;
    end

    assign from_pin   = (ctrl.src == SRC_PIN);
    assign fall       = pin_d & ~pin_s;
    assign lvl        = from_pin & ~ctrl.edge_mode & ~pin_s;
    assign periph_hit = (ctrl.src != SRC_SOFT) && !from_pin && periph_req[ctrl.src];
    assign set        = en & (sw_req | (from_pin & ctrl.edge_mode & fall) | periph_hit);

    always_ff @(posedge clk) begin
        if (rst)             pend <= 1'b0;
        else if (cancel_clr) pend <= 1'b0;
        else                 pend <= (pend & ~grant_clr) | set;
    end

    assign req      = en & (pend | lvl);
    assign view     = pend | lvl;
    assign sw_taken = en & sw_req;

    // R12: a cancelled channel holds no latched request afterwards
    assert_pend_cancel_R12: assert property (@(posedge clk) disable iff (rst)
        cancel_clr |=> !pend);

    // R3: a disabled channel never latches a request
    assert_pend_enable_R3: assert property (@(posedge clk) disable iff (rst)
        (!en && !pend) |=> !pend);

endmodule

// File: rtl/dmarb_arbiter.sv
module dmarb_arbiter
    import dmarb_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [NCH-1:0]   req,
    input  logic             prio_rr,
    input  logic             done,
    input  logic             cancel,
    output logic             grant_valid,
    output logic [IDX_W-1:0] grant_ch,
    output logic [NCH-1:0]   take
);
    arb_state_t       state;
    logic [IDX_W-1:0] last_q;
    logic [IDX_W-1:0] start;
    logic [IDX_W:0]   pk;
    logic             hit;
    logic [IDX_W-1:0] win;

    assign start = prio_rr ? (last_q + IDX_W'(1)) : '0;
    assign pk    = pick(req, start);
    assign hit   = pk[IDX_W];
    assign win   = pk[IDX_W-1:0];
    assign take  = (state == ARB_IDLE && hit) ? onehot(win) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ARB_IDLE;
            grant_ch <= '0;
            last_q   <= IDX_W'(NCH - 1);
        end else begin
            case (state)
                ARB_IDLE: if (hit) begin
                    state    <= ARB_BUSY;
                    grant_ch <= win;
                    last_q   <= win;
                end
                ARB_BUSY: if (done || cancel) state <= ARB_IDLE;
                default:  state <= ARB_IDLE;
            endcase
        end
    end

    assign grant_valid = (state == ARB_BUSY);

    // R9: an active grant keeps its channel until done or cancel
    assert_grant_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (grant_valid && !done && !cancel) |=> (grant_valid && $stable(grant_ch)));

    // R9: done or cancel always returns to idle
    assert_grant_end_R9: assert property (@(posedge clk) disable iff (rst)
        (grant_valid && (done || cancel)) |=> !grant_valid);

endmodule

// File: rtl/dmarb_tc.sv
module dmarb_tc #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic tc_en,
    input  logic busy,
    input  logic zero_sel,
    input  logic tc_pin_in,
    output logic tc_drive_low,
    output logic abort_fall
);
    logic                   zero_d;
    logic                   line_s, line_d;
    logic [SYNC_STAGES-1:0] drive_hist;
    logic                   own_mask;

    always_ff @(posedge clk) begin
        if (rst) begin
            zero_d       <= 1'b0;
            tc_drive_low <= 1'b0;
        end else begin
            zero_d       <= zero_sel;
            tc_drive_low <= tc_en & busy & zero_sel & ~zero_d;
        end
    end

    dmarb_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_line_sync (
        .clk (clk),
        .rst (rst),
        .d   (tc_pin_in),
        .q   (line_s)
    );

    // History of own drive, long enough to cover the synchronizer delay
    always_ff @(posedge clk) begin
        if (rst) begin
            line_d     <= 1'b1;
            drive_hist <= '0;
        end else begin
            line_d     <= line_s;
            drive_hist <= {drive_hist[SYNC_STAGES-2:0], tc_drive_low};
        end
    end

    assign own_mask   = tc_drive_low | (|drive_hist);
    assign abort_fall = tc_en & line_d & ~line_s & ~own_mask;

    // R11: the terminal-count pulse lasts one cycle
    assert_tc_single_R11: assert property (@(posedge clk) disable iff (rst)
        tc_drive_low |=> !tc_drive_low);

    // R11: no pulse unless the line was enabled
    assert_tc_enabled_R11: assert property (@(posedge clk) disable iff (rst)
        tc_drive_low |-> $past(tc_en));

endmodule

// File: rtl/dmarb_top.sv
module dmarb_top
    import dmarb_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NCH-1:0]    req_pin_n,
    input  logic [NSRC-1:0]   periph_req,
    input  logic              xfer_done,
    input  logic [NCH-1:0]    cnt_zero,
    input  logic              tc_pin_in,
    output logic              grant_valid,
    output logic [IDX_W-1:0]  grant_ch,
    output logic              xfer_cancel,
    output logic [NCH-2:0]    ack,
    output logic              tc_drive_low
);
    glb_ctrl_t            glb;
    logic [NCH-1:0]       ch_en, sw_req, sw_taken, req_view, req, take, cancel_clr;
    ch_ctrl_t [NCH-1:0]   ctrl;
    logic                 abort_fall;

    dmarb_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .sw_taken  (sw_taken),
        .req_view  (req_view),
        .glb       (glb),
        .ch_en     (ch_en),
        .sw_req    (sw_req),
        .ctrl      (ctrl)
    );

    assign cancel_clr = xfer_cancel ? onehot(grant_ch) : '0;

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        dmarb_chreq #(.SYNC_STAGES(SYNC_STAGES)) u_chreq (
            .clk        (clk),
            .rst        (rst),
            .pin_n      (req_pin_n[i]),
            .ctrl       (ctrl[i]),
            .en         (ch_en[i]),
            .sw_req     (sw_req[i]),
            .periph_req (periph_req),
            .grant_clr  (take[i]),
            .cancel_clr (cancel_clr[i]),
            .req        (req[i]),
            .view       (req_view[i]),
            .sw_taken   (sw_taken[i])
        );
    end

    dmarb_arbiter u_arb (
        .clk         (clk),
        .rst         (rst),
        .req         (req),
        .prio_rr     (glb.prio_rr),
        .done        (xfer_done),
        .cancel      (xfer_cancel),
        .grant_valid (grant_valid),
        .grant_ch    (grant_ch),
        .take        (take)
    );

    dmarb_tc #(.SYNC_STAGES(SYNC_STAGES)) u_tc (
        .clk          (clk),
        .rst          (rst),
        .tc_en        (glb.tc_en),
        .busy         (grant_valid),
        .zero_sel     (cnt_zero[grant_ch]),
        .tc_pin_in    (tc_pin_in),
        .tc_drive_low (tc_drive_low),
        .abort_fall   (abort_fall)
    );

    assign xfer_cancel = grant_valid & abort_fall;

    for (genvar i = 0; i < NCH - 1; i++) begin : g_ack
        assign ack[i] = grant_valid && (grant_ch == IDX_W'(i)) && ctrl[i].ack_en;
    end

    // R10: never two acknowledges at once
    assert_ack_onehot_R10: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ack));

    // R12: a cancel ends the grant on the next cycle
    assert_cancel_idle_R12: assert property (@(posedge clk) disable iff (rst)
        xfer_cancel |=> !grant_valid);

endmodule

// File: tb/dmarb_top_tb_top.sv
module dmarb_top_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [3:0]  req_pin_n = 4'hF;
    logic [15:0] periph_req = '0;
    logic        xfer_done = 1'b0;
    logic [3:0]  cnt_zero = '0;
    logic        ext_tc_low = 1'b0;
    logic        tc_pin_in;
    logic        grant_valid;
    logic [1:0]  grant_ch;
    logic        xfer_cancel;
    logic [2:0]  ack;
    logic        tc_drive_low;

    int total = 0;
    int fails = 0;
    int cyc = 0;

    always #10 clk = ~clk;

    assign tc_pin_in = ~(tc_drive_low | ext_tc_low);

    dmarb_top dut_i (
        .clk (clk), .rst (rst), .bus_wr (bus_wr), .bus_addr (bus_addr),
        .bus_wdata (bus_wdata), .bus_rdata (bus_rdata), .req_pin_n (req_pin_n),
        .periph_req (periph_req), .xfer_done (xfer_done), .cnt_zero (cnt_zero),
        .tc_pin_in (tc_pin_in), .grant_valid (grant_valid), .grant_ch (grant_ch),
        .xfer_cancel (xfer_cancel), .ack (ack), .tc_drive_low (tc_drive_low)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            total = total + 1;
            fails = fails + 1;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_grant(output bit ok);
        int i;
        ok = 1'b0;
        i = 0;
        while (i < 30 && !ok) begin
            @(negedge clk);
            if (grant_valid) ok = 1'b1;
            i++;
        end
    endtask

    task automatic finish_xfer();
        @(negedge clk);
        xfer_done = 1'b1;
        @(negedge clk);
        xfer_done = 1'b0;
    endtask

    // {prio_rr, sw mask[3:0], count[2:0], grant order 4x2 bits, first in LSBs}
    localparam logic [15:0] VECS [0:7] = '{
        16'h520D, 16'h7CE4, 16'hAA08, 16'hFC93,
        16'h620E, 16'hB209, 16'hDB13, 16'h7339
    };

    initial begin
        logic [7:0] d;
        bit ok;
        int cnt;
        bit seen;

        idle(5);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        chk("R1 grant_valid", grant_valid, 0);
        chk("R1 ack", ack, 0);
        chk("R1 tc_drive_low", tc_drive_low, 0);
        rd(3'd0, d); chk("R1 global reg", d, 0);
        rd(3'd1, d); chk("R1 enable reg", d, 0);
        rd(3'd5, d); chk("R1 ch1 ctrl", d, 0);

        // R3 / R13: software bit on a disabled channel stays set, no grant
        wr(3'd1, 8'h04);
        idle(10);
        chk("R3 no grant when disabled", grant_valid, 0);
        rd(3'd1, d); chk("R13 sw bit held while disabled", d, 8'h04);
        rd(3'd0, d); chk("R3 no latched flag", d[7:4], 0);
        wr(3'd1, 8'h00);

        // R2: flag nibble not writable; ctrl reads 6 bits
        wr(3'd0, 8'hF0);
        rd(3'd0, d); chk("R2 flag bits ignore writes", d, 0);
        wr(3'd7, 8'hFF);
        rd(3'd7, d); chk("R2 ctrl readback width", d, 8'h3F);
        wr(3'd7, 8'h00);

        // R4 / R5: vector table
        foreach (VECS[v]) begin
            wr(3'd0, {7'd0, VECS[v][15]});
            wr(3'd1, {4'hF, VECS[v][14:11]});
            for (int k = 0; k < int'(VECS[v][10:8]); k++) begin
                wait_grant(ok);
                chk(VECS[v][15] ? "R5 grant seen" : "R4 grant seen", ok, 1);
                chk(VECS[v][15] ? "R5 rotating order" : "R4 fixed order",
                    grant_ch, VECS[v][2*k +: 2]);
                chk("R10 ack off when disabled", ack, 0);
                finish_xfer();
            end
            idle(5);
            chk("R9 idle after vector", grant_valid, 0);
        end

        // R10: acknowledge on channel 0, none on channel 3
        wr(3'd4, 8'h20);
        wr(3'd1, 8'hF1);
        wait_grant(ok);
        chk("R10 ch0 granted", grant_ch, 0);
        chk("R10 ch0 ack", ack, 3'b001);
        finish_xfer();
        wr(3'd7, 8'h20);
        wr(3'd1, 8'hF8);
        wait_grant(ok);
        chk("R10 ch3 granted", grant_ch, 3);
        chk("R10 ch3 has no ack", ack, 0);
        finish_xfer();

        // R6: peripheral source 5 on channel 1
        wr(3'd5, 8'h05);
        @(negedge clk); periph_req[6] = 1'b1;
        @(negedge clk); periph_req[6] = 1'b0;
        idle(8);
        chk("R6 unselected periph ignored", grant_valid, 0);
        @(negedge clk); periph_req[5] = 1'b1;
        @(negedge clk); periph_req[5] = 1'b0;
        wait_grant(ok);
        chk("R6 periph grant", ok, 1);
        chk("R6 periph channel", grant_ch, 1);
        finish_xfer();

        // R7: edge-sensed pin on channel 2 with ack
        wr(3'd6, 8'h31);
        @(negedge clk); req_pin_n[2] = 1'b0;
        wait_grant(ok);
        chk("R7 edge grant channel", grant_ch, 2);
        chk("R7 ack ch2", ack, 3'b100);
        finish_xfer();
        idle(10);
        chk("R7 held pin no regrant", grant_valid, 0);
        req_pin_n[2] = 1'b1;

        // R8: level-sensed pin on channel 1
        wr(3'd5, 8'h01);
        @(negedge clk); req_pin_n[1] = 1'b0;
        wait_grant(ok);
        chk("R8 level grant channel", grant_ch, 1);
        finish_xfer();
        wait_grant(ok);
        chk("R8 regrant while low", ok, 1);
        chk("R8 regrant channel", grant_ch, 1);
        req_pin_n[1] = 1'b1;
        idle(6);
        finish_xfer();
        idle(10);
        chk("R8 no grant after release", grant_valid, 0);

        // R11: terminal-count pulse on channel 0
        wr(3'd0, 8'h02);
        wr(3'd1, 8'hF1);
        wait_grant(ok);
        chk("R11 ch0 granted", grant_ch, 0);
        @(negedge clk); cnt_zero[0] = 1'b1;
        cnt = 0; seen = 1'b0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (tc_drive_low) cnt++;
            if (xfer_cancel) seen = 1'b1;
            if (i == 0) cnt_zero[0] = 1'b0;
        end
        chk("R11 one-cycle pulse", cnt, 1);
        chk("R12 own pulse no cancel", seen, 0);
        chk("R12 grant kept after own pulse", grant_valid, 1);
        @(negedge clk); cnt_zero[2] = 1'b1;
        cnt = 0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (tc_drive_low) cnt++;
            if (i == 0) cnt_zero[2] = 1'b0;
        end
        chk("R11 inactive channel no pulse", cnt, 0);
        finish_xfer();

        // R12 / R13: abort on channel 3 clears its re-latched request
        wr(3'd1, 8'hF8);
        wait_grant(ok);
        chk("R12 ch3 granted", grant_ch, 3);
        wr(3'd1, 8'hF8);
        idle(2);
        rd(3'd1, d); chk("R13 sw bit self-cleared", d[3], 0);
        rd(3'd0, d); chk("R12 flag set before abort", d[7], 1);
        @(negedge clk); ext_tc_low = 1'b1;
        seen = 1'b0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (xfer_cancel) seen = 1'b1;
        end
        chk("R12 cancel raised", seen, 1);
        chk("R12 grant ended", grant_valid, 0);
        rd(3'd0, d); chk("R12 flag cleared by cancel", d[7], 0);
        idle(8);
        chk("R12 no regrant after cancel", grant_valid, 0);
        ext_tc_low = 1'b0;
        idle(5);

        // R12 / R11: line disabled
        wr(3'd0, 8'h00);
        wr(3'd1, 8'hF1);
        wait_grant(ok);
        @(negedge clk); ext_tc_low = 1'b1; cnt_zero[0] = 1'b1;
        cnt = 0; seen = 1'b0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (xfer_cancel) seen = 1'b1;
            if (tc_drive_low) cnt++;
            if (i == 0) cnt_zero[0] = 1'b0;
        end
        chk("R12 disabled line no cancel", seen, 0);
        chk("R12 grant kept", grant_valid, 1);
        chk("R11 disabled line no pulse", cnt, 0);
        ext_tc_low = 1'b0;
        finish_xfer();
        idle(4);
        chk("R9 idle at end", grant_valid, 0);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule